// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Register

This block keeps the pending interrupt state of one processor and turns it into a vector of level requests for that processor. The state has three parts. Software requests occupy the upper half of a 32-bit pending word. Bit 14 carries a local timer request, and bit 15 carries a level-15 request. Software raises and retires its own requests through a small word-addressed register port. A separate set port and a separate clear port make this possible without a read-modify-write.

A system-level router sits outside this block. It masks the shared sources, picks the target processor and maps each source to a priority level. It then hands this block a vector of hardware level bits. Those bits are merged into the readable pending word and into the request vector, but software cannot write them. A global-disable input suppresses the timer and level-15 requests. It leaves software requests untouched.

The request vector is registered. Every input or register change shows on it one clock later. Level 0 does not exist, so output bit 0 is never driven.

Top module: `intp_percpu_reg`

## Requirements
- R1: A read (select high, write low, all four byte enables high) at word offset 0 returns the pending word, with the router bits 15..1 ORed into bits 15..1. A read at any other offset, or with any partial byte-enable, returns zero.
- R2: A full write at word offset 1 clears each pending bit whose data bit is 1, but only bits 31..17 and bit 15. Bit 14 and every other bit are unaffected.
- R3: A full write at word offset 2 sets each pending bit whose data bit is 1, but only bits 31..17. A write at offset 0 or offset 3 changes nothing.
- R4: Pending bit n, for n in 17..31, drives output level n-16 whatever the global-disable input is.
- R5: Pending bit 14 follows the timer input level, sampled at each clock edge.
- R6: Pending bit 15 is set when the level-15 input rises, is cleared when that input is low, and is cleared by a clear write with data bit 15 set. When a clear write and a rising level-15 input occur in the same cycle, the clear wins. The bit then stays clear until the input rises again.
- R7: Pending bits 14 and 15 drive output levels 14 and 15 only while the global-disable input is low.
- R8: Router bits 15..1 drive the output levels of the same index without gating, and no register write changes them.
- R9: Output bit 0 is always 0, even when router bit 0 is high.
- R10: An access with any byte enable low neither reads nor writes.
- R11: The output vector is registered, so each change appears one clock after the cause. Reset clears the pending word and the output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_off | input | 4 | Word offset |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| tmr_req | input | 1 | Local timer request level |
| l15_req | input | 1 | Level-15 request level |
| glb_dis | input | 1 | Global disable for the timer and level-15 requests |
| rtr_lvl | input | 16 | Router level bits, bit i = level i |
| irl_out | output | 16 | Registered level requests, bit i = level i |

## Verification
The hardest state to reach is a level-15 bit that has been cleared by software while its input stays high. It requires a rising input and a clear write in the same cycle, or a clear write after the rise, followed by further cycles with the input held high. Directed steps reach this state, then release the input and raise it again. Constrained-random cycles mix accesses at all offsets, partial byte enables, toggling timer, disable and router inputs against a bench model.

// File: rtl/intp_pkg.sv
package intp_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_READ = 2'd1,
      OP_CLR  = 2'd2,
      OP_SET  = 2'd3
   } reg_op_e;

   // Mask with bits hi..lo set
   function automatic logic [31:0] span_mask(input int hi, input int lo);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/intp_bus_dec.sv
module intp_bus_dec
   import intp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 4,
   parameter int OFF_PEND = 0,
   parameter int OFF_CLR  = 1,
   parameter int OFF_SET  = 2
) (
   input  logic                 sel,
   input  logic                 wr,
   input  logic [OFF_W-1:0]     off,
   input  logic [DATA_W/8-1:0]  be,
   output reg_op_e              op,
   output logic                 rd_pend
);
   localparam int BE_W = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_chk_w
      $error("intp_bus_dec: DATA_W must be a byte multiple");
   end
   if (OFF_PEND == OFF_CLR || OFF_CLR == OFF_SET || OFF_PEND == OFF_SET) begin : g_chk_off
      $error("intp_bus_dec: offsets must differ");
   end

   logic full;
   assign full = (be == {BE_W{1'b1}});

   always_comb begin
      op      = OP_IDLE;
      rd_pend = 1'b0;
      if (sel && full) begin
         if (!wr) begin
            op      = OP_READ;
            rd_pend = (off == OFF_W'(OFF_PEND));
         end else if (off == OFF_W'(OFF_CLR)) begin
            op = OP_CLR;
         end else if (off == OFF_W'(OFF_SET)) begin
            op = OP_SET;
         end
      end
   end
endmodule

// File: rtl/intp_pend_store.sv
module intp_pend_store
   import intp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TMR_BIT = 14,
   parameter int L15_BIT = 15,
   parameter logic [DATA_W-1:0] SET_MASK = '0,
   parameter logic [DATA_W-1:0] CLR_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_op_e           op,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tmr_in,
   input  logic              l15_in,
   output logic [DATA_W-1:0] pend_q,
   output logic [DATA_W-1:0] pend_nxt
);
   localparam logic [DATA_W-1:0] TMR_M  = DATA_W'(1) << TMR_BIT;
   localparam logic [DATA_W-1:0] L15_M  = DATA_W'(1) << L15_BIT;
   localparam logic [DATA_W-1:0] KEEP_M = SET_MASK | TMR_M | L15_M;

   if (TMR_BIT == L15_BIT || TMR_BIT >= DATA_W || L15_BIT >= DATA_W) begin : g_chk_bits
      $error("intp_pend_store: bad timer/level-15 bit positions");
   end
   if ((SET_MASK & TMR_M) != '0) begin : g_chk_tmr
      $error("intp_pend_store: timer bit must not be software settable");
   end

   logic              l15_prev;
   logic              l15_rise;
   logic [DATA_W-1:0] set_v, clr_v;

   assign l15_rise = l15_in && !l15_prev;
   assign set_v    = (op == OP_SET) ? (wdata & SET_MASK) : '0;
   assign clr_v    = (op == OP_CLR) ? (wdata & CLR_MASK) : '0;

   always_comb begin
      pend_nxt          = pend_q | set_v;
      pend_nxt[TMR_BIT] = tmr_in;
      if (l15_rise)
         pend_nxt[L15_BIT] = 1'b1;
      else if (!l15_in)
         pend_nxt[L15_BIT] = 1'b0;
      // clear applied last so it wins over any set in the same cycle
      pend_nxt = (pend_nxt & ~clr_v) & KEEP_M;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         l15_prev <= 1'b0;
      end else begin
         pend_q   <= pend_nxt;
         l15_prev <= l15_in;
      end
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SET) |=> ((pend_q & $past(wdata & SET_MASK)) == $past(wdata & SET_MASK))); // R3
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLR) |=> ((pend_q & $past(wdata & CLR_MASK)) == '0)); // R2
   AST_TMR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_q[TMR_BIT] == $past(tmr_in))); // R5
   AST_L15_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !l15_in |=> !pend_q[L15_BIT]); // R6
endmodule

// File: rtl/intp_lvl_drive.sv
module intp_lvl_drive #(
   parameter int DATA_W     = 32,
   parameter int LVL_N      = 16,
   parameter int SOFT_SHIFT = 16,
   parameter int TMR_BIT    = 14,
   parameter int L15_BIT    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pend_nxt,
   input  logic              gdis,
   input  logic [LVL_N-1:0]  rtr,
   output logic [LVL_N-1:0]  lvl_q
);
   if (SOFT_SHIFT + LVL_N > DATA_W) begin : g_chk_fit
      $error("intp_lvl_drive: soft field exceeds data width");
   end

   logic [LVL_N-1:0] lvl_d;

   for (genvar k = 0; k < LVL_N; k++) begin : g_lvl
      if (k == 0) begin : g_none
         assign lvl_d[k] = 1'b0;   // no level 0
      end else if (k == TMR_BIT || k == L15_BIT) begin : g_gated
         assign lvl_d[k] = pend_nxt[k + SOFT_SHIFT] | rtr[k] | (pend_nxt[k] & !gdis);
      end else begin : g_plain
         assign lvl_d[k] = pend_nxt[k + SOFT_SHIFT] | rtr[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end
endmodule

// File: rtl/intp_percpu_reg.sv
module intp_percpu_reg
   import intp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 4,
   parameter int LVL_N    = 16,
   parameter int SOFT_LO  = 17,
   parameter int TMR_BIT  = 14,
   parameter int L15_BIT  = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                reg_wr,
   input  logic [OFF_W-1:0]    reg_off,
   input  logic [DATA_W/8-1:0] reg_be,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                tmr_req,
   input  logic                l15_req,
   input  logic                glb_dis,
   input  logic [LVL_N-1:0]    rtr_lvl,
   output logic [LVL_N-1:0]    irl_out
);
   localparam int SOFT_SHIFT = SOFT_LO - 1;
   localparam logic [DATA_W-1:0] SET_M = DATA_W'(span_mask(DATA_W - 1, SOFT_LO));
   localparam logic [DATA_W-1:0] CLR_M = SET_M | (DATA_W'(1) << L15_BIT);

   if (DATA_W != 32) begin : g_chk_dw
      $error("intp_percpu_reg: DATA_W must be 32");
   end
   if (LVL_N > SOFT_LO) begin : g_chk_lvl
      $error("intp_percpu_reg: levels overlap soft field");
   end

   reg_op_e           op;
   logic              rd_pend;
   logic [DATA_W-1:0] pend_q, pend_nxt;
   logic [DATA_W-1:0] view;

   intp_bus_dec #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dec (
      .sel(reg_sel), .wr(reg_wr), .off(reg_off), .be(reg_be),
      .op(op), .rd_pend(rd_pend));

   intp_pend_store #(.DATA_W(DATA_W), .TMR_BIT(TMR_BIT), .L15_BIT(L15_BIT),
                     .SET_MASK(SET_M), .CLR_MASK(CLR_M)) u_store (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(reg_wdata),
      .tmr_in(tmr_req), .l15_in(l15_req),
      .pend_q(pend_q), .pend_nxt(pend_nxt));

   intp_lvl_drive #(.DATA_W(DATA_W), .LVL_N(LVL_N), .SOFT_SHIFT(SOFT_SHIFT),
                    .TMR_BIT(TMR_BIT), .L15_BIT(L15_BIT)) u_drv (
      .clk(clk), .rst_n(rst_n), .pend_nxt(pend_nxt), .gdis(glb_dis),
      .rtr(rtr_lvl), .lvl_q(irl_out));

   // router bits are merged for reading only; bit 0 carries no level
   assign view      = pend_q | DATA_W'({rtr_lvl[LVL_N-1:1], 1'b0});
   assign reg_rdata = rd_pend ? view : '0;

   AST_SOFT_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q[DATA_W-1:SOFT_LO] & ~irl_out[LVL_N-1:1]) == '0)); // R4
   AST_DIS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_dis && !rtr_lvl[TMR_BIT] && !pend_nxt[TMR_BIT + SOFT_SHIFT]) |=> !irl_out[TMR_BIT]); // R7
   AST_RTR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(rtr_lvl) & ~irl_out) >> 1) == '0)); // R8
   AST_LVL0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rtr_lvl[0]) |=> !irl_out[0]); // R9
endmodule

// File: tb/intp_percpu_reg_test.sv
module intp_percpu_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 0, wr = 0;
   logic [3:0]  off = 0, be = 0;
   logic [31:0] wd = 0;
   logic [31:0] rdata;
   logic        tmr = 0, l15 = 0, gdis = 0;
   logic [15:0] rtr = 0;
   logic [15:0] irl;

   int n_chk = 0, n_bad = 0;
   bit done = 0, summ = 0;

   // bench model
   logic [31:0] m_pend = 0;
   logic        m_l15p = 0;
   logic [15:0] m_irl = 0;

   localparam logic [31:0] SETM = 32'hFFFE_0000;
   localparam logic [31:0] CLRM = 32'hFFFE_8000;

   always #5 clk = ~clk;

   intp_percpu_reg uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_off(off),
      .reg_be(be), .reg_wdata(wd), .reg_rdata(rdata), .tmr_req(tmr),
      .l15_req(l15), .glb_dis(gdis), .rtr_lvl(rtr), .irl_out(irl));

   function automatic logic [31:0] f_view(input logic [31:0] p, input logic [15:0] r);
      return p | {16'h0, r[15:1], 1'b0};
   endfunction

   function automatic logic [31:0] f_next(input logic [31:0] p, input logic pl15);
      logic [31:0] n;
      logic full = (be == 4'hF);
      n = p;
      if (sel && wr && full && off == 4'd2) n |= wd & SETM;
      n[14] = tmr;
      if (l15 && !pl15) n[15] = 1'b1;
      else if (!l15)    n[15] = 1'b0;
      if (sel && wr && full && off == 4'd1) n &= ~(wd & CLRM);
      return n;
   endfunction

   function automatic logic [15:0] f_lvl(input logic [31:0] n);
      logic [15:0] l;
      l = n[31:16] | rtr;
      if (!gdis) l |= {n[15:14], 14'h0};
      l[0] = 1'b0;
      return l;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic s, input logic w, input logic [3:0] o, input logic [3:0] b,
                        input logic [31:0] d, input logic t, input logic f, input logic g,
                        input logic [15:0] r);
      sel = s; wr = w; off = o; be = b; wd = d; tmr = t; l15 = f; gdis = g; rtr = r;
   endtask

   // called just after a negedge with inputs set: checks read data, steps one edge, checks outputs
   task automatic step(input string tag);
      logic [31:0] nx;
      #1;
      chk({tag, " R1/R10 rdata"}, rdata,
          (sel && !wr && be == 4'hF && off == 4'd0) ? f_view(m_pend, rtr) : 32'h0);
      nx = f_next(m_pend, m_l15p);
      m_irl = f_lvl(nx);
      @(posedge clk);
      m_pend = nx;
      m_l15p = l15;
      @(negedge clk);
      chk({tag, " R11 irl"}, {16'h0, irl}, {16'h0, m_irl});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R11 act=hung exp=done");
         if (!summ) begin
            summ = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         end
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R11 reset irl", {16'h0, irl}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      drive(1, 0, 0, 4'hF, 0, 0, 0, 0, 0); step("R11 reset read");
      // all soft set with disable high: ungated
      drive(1, 1, 2, 4'hF, 32'hFFFF_FFFF, 0, 0, 1, 0); step("R3/R4 set all");
      drive(1, 0, 0, 4'hF, 0, 0, 0, 1, 0); step("R1 read soft");
      drive(1, 1, 1, 4'hF, 32'h5555_5555, 0, 0, 1, 0); step("R2 clear some");
      drive(1, 1, 1, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 0); step("R2/R5 clear all keeps timer");
      drive(1, 0, 0, 4'hF, 0, 1, 0, 0, 0); step("R5 timer visible");
      drive(0, 0, 0, 0, 0, 1, 0, 1, 0); step("R7 timer gated");
      // level-15 rise with simultaneous clear: clear wins, stays clear while high
      drive(1, 1, 1, 4'hF, 32'h0000_8000, 0, 1, 0, 0); step("R6 clear wins rise");
      drive(1, 0, 0, 4'hF, 0, 0, 1, 0, 0); step("R6 stays clear");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0); step("R6 drop");
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0); step("R6 rise sets");
      drive(0, 0, 0, 0, 0, 0, 1, 1, 0); step("R7 l15 gated");
      drive(1, 1, 1, 4'hF, 32'h0000_8000, 0, 1, 0, 0); step("R6 clear later");
      // partial byte enables do nothing
      drive(1, 1, 2, 4'h7, 32'hFFFF_0000, 0, 0, 0, 0); step("R10 partial set");
      drive(1, 0, 0, 4'hE, 0, 0, 0, 0, 0); step("R10 partial read");
      // router bits, bit 0, and writes to other offsets
      drive(1, 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 1, 16'hFFFF); step("R8/R9 router");
      drive(1, 1, 3, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 16'h0001); step("R3/R9 off3 write");
      drive(1, 1, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 16'h2AAA); step("R8 clear router");
      drive(1, 0, 0, 4'hF, 0, 0, 0, 0, 16'h2AAA); step("R1/R8 read router");
      drive(1, 0, 5, 4'hF, 0, 0, 0, 0, 16'h2AAA); step("R1 other offset");
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] b = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
         drive($urandom % 4 != 0, $urandom % 2 == 1, 4'($urandom % 4), b, $urandom,
               $urandom % 3 == 0, $urandom % 4 == 0, $urandom % 3 == 0,
               ($urandom % 2 == 0) ? 16'($urandom) : 16'h0);
         step("RND R1/R2/R3/R4/R6/R7/R8");
      end
      done = 1;
      if (!summ) begin
         summ = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      end
      $finish;
   end
endmodule